// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Unit

This block is a memory-mapped timer peripheral. A single shared prescaler divides the system clock into ticks, and those ticks drive up to eight independent down-counting timers. Each timer expires when its counter passes below zero, one tick after it reaches zero. At expiry the timer either reloads and keeps running or stops, depending on its restart setting. When interrupts are enabled for that timer, expiry also raises a one-cycle interrupt pulse on its own output line and sets a sticky pending flag.

Software drives the block through a simple word-aligned register bus. The bus has a byte address, write data, a write strobe, a read strobe and a combinational read data port. The unit window sits at byte offsets 0x00 to 0x0F. Timer n has a window at 0x10 + 0x10*n. Inside a timer window, the counter is at +0x0, the reload value at +0x4 and the control word at +0x8. The number of timers is a parameter.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every readable register is 0 and all interrupt outputs are low, except the unit configuration word. The prescaler counter, prescaler reload, timer counters, timer reloads and control words all read 0.
- R2: Register access and readback work as follows:
  - A timer's counter (+0x0) and reload (+0x4) read back the last value written.
  - Control bits 5 and 6 read back as stored and have no effect.
  - The unit configuration word (0x08) is read-only and returns the number of timers.
- R3: The prescaler works as follows:
  - It counts down from its reload value and gives one tick each time it passes zero, so it ticks every (reload + 1) cycles.
  - Writing the prescaler reload (0x04) also loads the prescaler counter (0x00).
  - Writing 0x00 loads only the counter.
- R4: An enabled timer expires after (counter + 1) prescaler ticks.
  - Suppose the prescaler reload P is written in the cycle just before the timer's control word, and that control write sets enable and load.
  - The interrupt is then visible C+1 cycles after the control write edge when P = 0, and (P+1)(C+1)-1 cycles after it when P > 0.
- R5: On expiry with interrupt enable set (control bit 3), only that timer's interrupt output is high, and only for the one cycle after the expiry edge. With interrupt enable clear, no interrupt is raised.
- R6: The pending flag (control bit 4) behaves as follows:
  - It is set on expiry only when interrupt enable is set.
  - Writing 1 to it clears it, and writing 0 leaves it unchanged.
  - Hardware never clears it.
- R7: With restart set (control bit 1), expiry reloads the counter from the reload register and counting continues. Interrupts then repeat every (reload + 1)(P + 1) cycles.
- R8: With restart clear, expiry clears the enable bit (control bit 0) and the counter wraps to all ones and holds there.
- R9: Writing 1 to the load bit (control bit 2) copies the reload value into the counter at that write edge. The load bit always reads 0.
- R10: While the enable bit is clear, the counter holds its value.
- R11: Reads of an unimplemented timer window, or of a misaligned address (byte address bits 1:0 not zero), return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe; the write takes effect at the rising edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data: combinational from addr while rd_en is high, 0 otherwise |
| irq | output | N_TIMERS | One interrupt line per timer; a one-cycle pulse on each expiry |

## Verification
Reads are combinational, so each value is sampled within the same low clock phase in which the read strobe is driven. A write is visible in the phase after its rising edge. An expiry takes effect at a rising edge and the interrupt is registered, so it appears in the low phase after that edge. The bench therefore counts rising edges from the control write edge until the interrupt is first seen, then compares the count with the closed-form value from R4 or R7 for each prescaler and counter value in a sweep. It checks the low level in the next phase to confirm that the pulse lasts one cycle. Status is read back in the cycle after the pulse, when the counter wrap, the enable clear and the pending set have all been registered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int MAX_TIMERS = 8;

    // control word bit positions (software visible)
    localparam int CB_EN    = 0;
    localparam int CB_RST   = 1;
    localparam int CB_LOAD  = 2;
    localparam int CB_IE    = 3;
    localparam int CB_IP    = 4;
    localparam int CB_CHAIN = 5;
    localparam int CB_DBG   = 6;

    typedef enum logic [1:0] {
        OFS_CNT  = 2'd0,
        OFS_RLD  = 2'd1,
        OFS_CTL  = 2'd2,
        OFS_NONE = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic dbg;
        logic chain;
        logic ip;
        logic ie;
        logic rst;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic              wr;
        reg_ofs_e          ofs;
        logic [DATA_W-1:0] data;
    } chan_wr_t;

    function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[CB_EN]    = c.en;
        w[CB_RST]   = c.rst;
        w[CB_LOAD]  = 1'b0;
        w[CB_IE]    = c.ie;
        w[CB_IP]    = c.ip;
        w[CB_CHAIN] = c.chain;
        w[CB_DBG]   = c.dbg;
        return w;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_val_i,
    input  logic             wr_rld_i,
    input  logic [PSC_W-1:0] wdata_i,
    output logic             tick_o,
    output logic [PSC_W-1:0] cnt_o,
    output logic [PSC_W-1:0] rld_o
);

    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] rld_q;

    assign tick_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (wr_rld_i) begin
            rld_q <= wdata_i;
            cnt_q <= wdata_i;
        end else if (wr_val_i) begin
            cnt_q <= wdata_i;
        end else if (cnt_q == '0) begin
            cnt_q <= rld_q;
        end else begin
            cnt_q <= cnt_q - PSC_W'(1);
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  chan_wr_t         wr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output ctl_t             ctl_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    ctl_t             ctl_q;
    logic             irq_q;
    logic             ufl;

    // underflow: enabled, prescaler tick, counter already at zero
    assign ufl = ctl_q.en && tick_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= ufl && ctl_q.ie;

            // hardware counting
            if (ufl) begin
                if (ctl_q.rst) begin
                    cnt_q <= rld_q;
                end else begin
                    cnt_q    <= '1;
                    ctl_q.en <= 1'b0;
                end
            end else if (ctl_q.en && tick_i) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end

            // software writes win over counting
            if (wr_i.wr) begin
                case (wr_i.ofs)
                    OFS_CNT: cnt_q <= wr_i.data[CNT_W-1:0];
                    OFS_RLD: rld_q <= wr_i.data[CNT_W-1:0];
                    OFS_CTL: begin
                        ctl_q.en    <= wr_i.data[CB_EN];
                        ctl_q.rst   <= wr_i.data[CB_RST];
                        ctl_q.ie    <= wr_i.data[CB_IE];
                        ctl_q.chain <= wr_i.data[CB_CHAIN];
                        ctl_q.dbg   <= wr_i.data[CB_DBG];
                        if (wr_i.data[CB_LOAD]) begin
                            cnt_q <= rld_q;
                        end
                        if (wr_i.data[CB_IP]) begin
                            ctl_q.ip <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end

            // pending set has priority over a same-cycle clear
            if (ufl && ctl_q.ie) begin
                ctl_q.ip <= 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = ctl_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int N_TIMERS = 8
) (
    input  logic [ADDR_W-1:0]                rd_addr_i,
    input  logic                             rd_en_i,
    input  logic [DATA_W-1:0]                psc_cnt_i,
    input  logic [DATA_W-1:0]                psc_rld_i,
    input  logic [N_TIMERS-1:0][DATA_W-1:0]  cnt_w_i,
    input  logic [N_TIMERS-1:0][DATA_W-1:0]  rld_w_i,
    input  logic [N_TIMERS-1:0][DATA_W-1:0]  ctl_w_i,
    output logic [DATA_W-1:0]                rd_data_o
);

    logic [3:0] win;
    reg_ofs_e   ofs;
    logic       aligned;

    assign win     = rd_addr_i[7:4];
    assign ofs     = reg_ofs_e'(rd_addr_i[3:2]);
    assign aligned = (rd_addr_i[1:0] == 2'b00);

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i && aligned) begin
            if (win == 4'd0) begin
                case (ofs)
                    OFS_CNT: rd_data_o = psc_cnt_i;
                    OFS_RLD: rd_data_o = psc_rld_i;
                    OFS_CTL: rd_data_o = DATA_W'(N_TIMERS);
                    default: rd_data_o = '0;
                endcase
            end else begin
                for (int i = 0; i < N_TIMERS; i++) begin
                    if (win == 4'(i + 1)) begin
                        case (ofs)
                            OFS_CNT: rd_data_o = cnt_w_i[i];
                            OFS_RLD: rd_data_o = rld_w_i[i];
                            OFS_CTL: rd_data_o = ctl_w_i[i];
                            default: rd_data_o = '0;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int N_TIMERS = 8,
    parameter int CNT_W    = 32,
    parameter int PSC_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          addr,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    output logic [31:0]         rd_data,
    output logic [N_TIMERS-1:0] irq
);

    logic       aligned;
    logic [3:0] win;
    reg_ofs_e   ofs;
    logic       psc_wr_val;
    logic       psc_wr_rld;
    logic       tick;

    logic [PSC_W-1:0] psc_cnt;
    logic [PSC_W-1:0] psc_rld;

    logic [N_TIMERS-1:0][DATA_W-1:0] cnt_w;
    logic [N_TIMERS-1:0][DATA_W-1:0] rld_w;
    logic [N_TIMERS-1:0][DATA_W-1:0] ctl_w;

    // observation points for the bound checker
    logic [N_TIMERS-1:0]            chan_ip;
    logic [N_TIMERS-1:0]            chan_ie;
    logic [N_TIMERS-1:0]            chan_en;
    logic [N_TIMERS-1:0][CNT_W-1:0] chan_cnt;

    assign aligned    = (addr[1:0] == 2'b00);
    assign win        = addr[7:4];
    assign ofs        = reg_ofs_e'(addr[3:2]);
    assign psc_wr_val = wr_en && aligned && (win == 4'd0) && (ofs == OFS_CNT);
    assign psc_wr_rld = wr_en && aligned && (win == 4'd0) && (ofs == OFS_RLD);

    tmr_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk      (clk),
        .rst      (rst),
        .wr_val_i (psc_wr_val),
        .wr_rld_i (psc_wr_rld),
        .wdata_i  (wr_data[PSC_W-1:0]),
        .tick_o   (tick),
        .cnt_o    (psc_cnt),
        .rld_o    (psc_rld)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chan
        chan_wr_t         wr_c;
        logic [CNT_W-1:0] cnt_c;
        logic [CNT_W-1:0] rld_c;
        ctl_t             ctl_c;

        assign wr_c.wr   = wr_en && aligned && (win == 4'(i + 1)) && (ofs != OFS_NONE);
        assign wr_c.ofs  = ofs;
        assign wr_c.data = wr_data;

        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick),
            .wr_i   (wr_c),
            .cnt_o  (cnt_c),
            .rld_o  (rld_c),
            .ctl_o  (ctl_c),
            .irq_o  (irq[i])
        );

        assign cnt_w[i]    = DATA_W'(cnt_c);
        assign rld_w[i]    = DATA_W'(rld_c);
        assign ctl_w[i]    = ctl_to_word(ctl_c);
        assign chan_ip[i]  = ctl_c.ip;
        assign chan_ie[i]  = ctl_c.ie;
        assign chan_en[i]  = ctl_c.en;
        assign chan_cnt[i] = cnt_c;
    end

    tmr_rdmux #(
        .N_TIMERS (N_TIMERS)
    ) u_rd (
        .rd_addr_i (addr),
        .rd_en_i   (rd_en),
        .psc_cnt_i (DATA_W'(psc_cnt)),
        .psc_rld_i (DATA_W'(psc_rld)),
        .cnt_w_i   (cnt_w),
        .rld_w_i   (rld_w),
        .ctl_w_i   (ctl_w),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int N_TIMERS = 8,
    parameter int CNT_W    = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic [7:0]                      addr,
    input logic                            wr_en,
    input logic                            wr_ip,
    input logic                            rd_en,
    input logic [31:0]                     rd_data,
    input logic [N_TIMERS-1:0]             irq,
    input logic [N_TIMERS-1:0]             chan_ip,
    input logic [N_TIMERS-1:0]             chan_ie,
    input logic [N_TIMERS-1:0]             chan_en,
    input logic [N_TIMERS-1:0][CNT_W-1:0]  chan_cnt
);

    // R9
    load_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] == 2'b00 && addr[3:2] == 2'd2 && addr[7:4] != 4'd0)
        |-> (rd_data[2] == 1'b0));

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr[1:0] != 2'b00 || 32'(addr[7:4]) > N_TIMERS))
        |-> (rd_data == 32'd0));

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
        logic clr_hit;
        logic win_hit;
        assign clr_hit = wr_en && wr_ip && (addr == 8'(16 * (i + 1) + 8));
        assign win_hit = wr_en && (addr[7:4] == 4'(i + 1));

        // R5
        irq_has_pending_chk: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> chan_ip[i]);

        // R6
        pending_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (chan_ip[i] && !clr_hit) |=> chan_ip[i]);

        // R6
        pending_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(chan_ip[i]) |-> $past(chan_ie[i]));

        // R10
        frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            (!chan_en[i] && !win_hit) |=> $stable(chan_cnt[i]));
    end

endmodule

bind tmr_unit tmr_unit_chk #(
    .N_TIMERS (N_TIMERS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_ip    (wr_data[4]),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .irq      (irq),
    .chan_ip  (chan_ip),
    .chan_ie  (chan_ie),
    .chan_en  (chan_en),
    .chan_cnt (chan_cnt)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    addr;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic          rd_en;
    logic [31:0]   rd_data;
    logic [NT-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_unit #(
        .N_TIMERS (NT),
        .CNT_W    (32),
        .PSC_W    (32)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [7:0] a_cnt(input int t); return 8'(16 * (t + 1));     endfunction
    function automatic logic [7:0] a_rld(input int t); return 8'(16 * (t + 1) + 4); endfunction
    function automatic logic [7:0] a_ctl(input int t); return 8'(16 * (t + 1) + 8); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called in the low phase; write takes effect at the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr  = a;
        rd_en = 1'b1;
        #1;
        d     = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // counts rising edges until irq[t] is seen; returns -1 when not seen
    task automatic wait_irq(input int t, input int maxn, output int n);
        n = -1;
        for (int k = 1; k <= maxn; k++) begin
            step();
            if (irq[t]) begin
                n = k;
                break;
            end
        end
    endtask

    function automatic int exp_cycles(input int p, input int c);
        if (p == 0) return c + 1;
        return (p + 1) * (c + 1) - 1;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          n;
        int          cvals [4] = '{0, 1, 3, 6};

        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        rd(8'h00, v); chk("R1 psc cnt", v, 0);
        rd(8'h04, v); chk("R1 psc rld", v, 0);
        for (int t = 0; t < NT; t++) begin
            rd(a_cnt(t), v); chk("R1 cnt", v, 0);
            rd(a_rld(t), v); chk("R1 rld", v, 0);
            rd(a_ctl(t), v); chk("R1 ctl", v, 0);
        end

        // R2 unit config, readback, chain/debug storage
        rd(8'h08, v); chk("R2 unit cfg", v, NT);
        wr(a_cnt(1), 32'd77);   rd(a_cnt(1), v); chk("R2 cnt rb", v, 77);
        wr(a_rld(1), 32'hABCD); rd(a_rld(1), v); chk("R2 rld rb", v, 32'hABCD);
        wr(a_ctl(2), 32'h60);   rd(a_ctl(2), v); chk("R2 ctl 5/6", v, 32'h60);
        wr(a_ctl(2), 32'h0);

        // R3 prescaler countdown and reload write
        wr(8'h04, 32'd4); rd(8'h00, v); chk("R3 rld loads cnt", v, 4);
        rd(8'h04, v); chk("R3 rld rb", v, 4);
        step(); rd(8'h00, v); chk("R3 count down", v, 3);
        wr(8'h00, 32'd2); rd(8'h00, v); chk("R3 val write", v, 2);
        rd(8'h04, v); chk("R3 rld kept", v, 4);
        step(); step(); step(); rd(8'h00, v); chk("R3 wrap to rld", v, 4);

        // R9 load bit
        wr(a_rld(0), 32'h1234);
        wr(a_ctl(0), 32'h4);
        rd(a_cnt(0), v); chk("R9 load copies", v, 32'h1234);
        rd(a_ctl(0), v); chk("R9 load reads 0", v, 0);

        // R11 unimplemented window and misaligned access
        wr(8'h44, 32'd5);
        rd(8'h44, v); chk("R11 unimpl read", v, 0);
        rd(8'h48, v); chk("R11 unimpl ctl", v, 0);
        wr(8'h15, 32'd9);
        rd(8'h15, v); chk("R11 misaligned read", v, 0);
        rd(a_rld(0), v); chk("R11 no write effect", v, 32'h1234);

        // R10 freeze while disabled
        wr(8'h04, 32'd0);
        wr(a_rld(0), 32'd100);
        wr(a_ctl(0), 32'h5);
        wr(a_ctl(0), 32'h0);
        rd(a_cnt(0), v); chk("R10 one decrement", v, 99);
        repeat (5) step();
        rd(a_cnt(0), v); chk("R10 frozen", v, 99);

        // R4 R5 R6 R8 sweep over prescaler, count and timer
        for (int p = 0; p < 4; p++) begin
            for (int ci = 0; ci < 4; ci++) begin
                int c = cvals[ci];
                int t = (p + ci) % NT;
                wr(a_rld(t), 32'(c));
                wr(8'h04, 32'(p));
                wr(a_ctl(t), 32'hD);
                wait_irq(t, 64, n);
                chk("R4 expiry cycles", 32'(n), 32'(exp_cycles(p, c)));
                chk("R5 only own irq", 32'(irq), 32'(1 << t));
                step();
                chk("R5 one cycle pulse", 32'(irq), 32'd0);
                rd(a_ctl(t), v); chk("R8 R6 ctl after expiry", v, 32'h18);
                rd(a_cnt(t), v); chk("R8 cnt wraps", v, 32'hFFFF_FFFF);
                repeat (p + 1) step();
                rd(a_cnt(t), v); chk("R8 stopped", v, 32'hFFFF_FFFF);
                wr(a_ctl(t), 32'h10);
                rd(a_ctl(t), v); chk("R6 w1c", v, 0);
            end
        end

        // R5 R6 no interrupt when interrupt enable clear
        wr(a_rld(2), 32'd2);
        wr(8'h04, 32'd0);
        wr(a_ctl(2), 32'h5);
        wait_irq(2, 8, n);
        chk("R5 no irq without ie", 32'(n), 32'hFFFF_FFFF);
        rd(a_ctl(2), v); chk("R6 no pending without ie", v, 0);

        // R6 write 0 keeps, write 1 clears
        wr(a_rld(2), 32'd0);
        wr(a_ctl(2), 32'hD);
        wait_irq(2, 8, n);
        chk("R6 setup irq", 32'(n), 32'd1);
        wr(a_ctl(2), 32'h08);
        rd(a_ctl(2), v); chk("R6 write 0 keeps", v, 32'h18);
        wr(a_ctl(2), 32'h18);
        rd(a_ctl(2), v); chk("R6 write 1 clears", v, 32'h08);
        wr(a_ctl(2), 32'h0);

        // R7 restart: reload 2, prescaler 1, period 6
        wr(a_rld(1), 32'd2);
        wr(8'h04, 32'd1);
        wr(a_ctl(1), 32'hF);
        wait_irq(1, 64, n); chk("R7 first expiry", 32'(n), 32'(exp_cycles(1, 2)));
        wait_irq(1, 64, n); chk("R7 period", 32'(n), 32'd6);
        wait_irq(1, 64, n); chk("R7 period again", 32'(n), 32'd6);
        rd(a_ctl(1), v); chk("R7 still enabled", v, 32'h1B);
        wr(a_ctl(1), 32'h10);
        rd(a_ctl(1), v); chk("R7 stopped by sw", v, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule